// File: doc/BRIEF.md
# eMMC Boot Command Line Decoder

This block listens to the command line of an eMMC-style boot link. The line is sampled on the rising edge of the host clock. The host keeps that clock running for long stretches while the line sits high. The decoder starts a frame on the first zero it samples while armed, so a frame can begin at any bit offset. It then shifts in 48 bits, most significant bit first, and compares the whole word against three fixed boot-sequence commands. For each frame it emits a one-cycle `cmd_valid` pulse together with a 2-bit code. The code names the command, or marks the frame as unrecognised.

After a frame the decoder stays deaf until the line returns high for at least one sample, and only then re-arms for the next start bit. The block never drives the line. It does not compute CRC7 and does not interpret argument fields: a frame is accepted only if every bit matches one of the three patterns.

Top module: `emmc_boot_cmd_decoder`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the decoder returns to waiting for a start bit, and after that edge `cmd_valid` is 0 and `cmd_code` is 0.
- R2: While armed, any number of consecutive samples of 1 on `cmd_in` produce no pulse.
- R3: While armed, the first sampled 0 is bit 47 of a new frame. The next 47 samples fill bits 46 down to 0, whatever the number of idle ones before the frame.
- R4: A frame equal to 0x400000000095 is reported with code 0.
- R5: A frame equal to 0x40F0F0F0F0FD is reported with code 1.
- R6: A frame equal to 0x40FFFFFFFAE5 is reported with code 2.
- R7: Any other 48-bit frame is reported with code 3, including one differing from a known pattern in a single bit.
- R8: `cmd_valid` is high for exactly one cycle, starting on the clock edge right after the edge that sampled bit 0 of the frame.
- R9: After a frame, samples of 0 are ignored until a 1 is sampled. A single sampled 1 re-arms the decoder, so the next sample can start a frame.
- R10: `cmd_code` holds its last reported value between pulses.
- R11: A reset in the middle of a frame discards the partial frame without any pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 1 | Serial command line, idles high |
| cmd_valid | output | 1 | One-cycle pulse marking a classified frame |
| cmd_code | output | 2 | 0 idle, 1 pre-idle, 2 boot, 3 unrecognised |

## Verification
Two events can fall in the same cycle: the result pulse of one frame and the re-arm decision on the sample that follows its last bit. The bench provokes this by holding the line low straight after a boot frame, which must produce no new frame while the pulse appears. It also follows a frame with exactly one idle bit and then starts the next frame at once. The pulse count and codes show that the zeros were discarded and that the single 1 was enough to re-arm. Sweeps over every single-bit corruption of each known frame, sent at varying idle offsets, check the classification against values computed in the bench.

// File: rtl/emmc_cmd_pkg.sv
package emmc_cmd_pkg;
  localparam int FRAME_BITS = 48;
  localparam int NUM_KNOWN  = 3;

  typedef enum logic [1:0] {
    CODE_IDLE     = 2'd0,
    CODE_PRE_IDLE = 2'd1,
    CODE_BOOT     = 2'd2,
    CODE_ERROR    = 2'd3
  } cmd_code_t;

  typedef enum logic [1:0] {
    TRK_ARMED   = 2'd0,
    TRK_CAPTURE = 2'd1,
    TRK_REARM   = 2'd2
  } trk_state_t;

  // index i of this table reports code i
  localparam logic [FRAME_BITS-1:0] KNOWN_FRAMES [NUM_KNOWN] = '{
    48'h400000000095,
    48'h40F0F0F0F0FD,
    48'h40FFFFFFFAE5
  };
endpackage

// File: rtl/emmc_cmd_tracker.sv
module emmc_cmd_tracker
  import emmc_cmd_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_in,
  output logic shift_en,
  output logic frame_done
);
  localparam int CNT_W = $clog2(NBITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBITS - 1);

  trk_state_t       state;
  logic [CNT_W-1:0] bit_cnt;

  // the start bit itself is shifted in on the edge that detects it
  assign shift_en = ((state == TRK_ARMED) && !cmd_in) || (state == TRK_CAPTURE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TRK_ARMED;
      bit_cnt    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (state)
        TRK_ARMED: begin
          if (!cmd_in) begin
            state   <= TRK_CAPTURE;
            bit_cnt <= CNT_W'(1);
          end
        end
        TRK_CAPTURE: begin
          if (bit_cnt == LAST_IDX) begin
            state      <= TRK_REARM;
            bit_cnt    <= '0;
            frame_done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
        TRK_REARM: begin
          if (cmd_in) state <= TRK_ARMED;
        end
        default: state <= TRK_ARMED;
      endcase
    end
  end
endmodule

// File: rtl/emmc_cmd_shifter.sv
module emmc_cmd_shifter #(
  parameter int NBITS = 48
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic             cmd_in,
  output logic [NBITS-1:0] frame
);
  always_ff @(posedge clk) begin
    if (shift_en) frame <= {frame[NBITS-2:0], cmd_in};
  end
endmodule

// File: rtl/emmc_cmd_matcher.sv
module emmc_cmd_matcher
  import emmc_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  cmd_valid,
  output logic [1:0]            cmd_code
);
  logic [NUM_KNOWN-1:0] hit;
  cmd_code_t            match_code;

  for (genvar g = 0; g < NUM_KNOWN; g++) begin : g_cmp
    assign hit[g] = (frame == KNOWN_FRAMES[g]);
  end

  always_comb begin
    match_code = CODE_ERROR;
    for (int i = NUM_KNOWN - 1; i >= 0; i--) begin
      if (hit[i]) match_code = cmd_code_t'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_code  <= CODE_IDLE;
    end else begin
      cmd_valid <= frame_done;
      if (frame_done) cmd_code <= match_code;
    end
  end
endmodule

// File: rtl/emmc_boot_cmd_decoder.sv
module emmc_boot_cmd_decoder
  import emmc_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_in,
  output logic       cmd_valid,
  output logic [1:0] cmd_code
);
  logic                  shift_en;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame;

  emmc_cmd_tracker #(.NBITS(FRAME_BITS)) u_tracker (
    .clk        (clk),
    .rst        (rst),
    .cmd_in     (cmd_in),
    .shift_en   (shift_en),
    .frame_done (frame_done)
  );

  emmc_cmd_shifter #(.NBITS(FRAME_BITS)) u_shifter (
    .clk      (clk),
    .shift_en (shift_en),
    .cmd_in   (cmd_in),
    .frame    (frame)
  );

  emmc_cmd_matcher u_matcher (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .frame      (frame),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code)
  );
endmodule

// File: rtl/emmc_boot_cmd_decoder_checker.sv
module emmc_boot_cmd_decoder_checker
  import emmc_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_in,
  input logic       cmd_valid,
  input logic [1:0] cmd_code
);
  localparam int GAP_W = $clog2(FRAME_BITS + 1);
  logic [GAP_W-1:0] gap;

  // cycles since reset or since the last pulse, saturating at one frame
  always_ff @(posedge clk) begin
    if (rst || cmd_valid) gap <= '0;
    else if (gap != GAP_W'(FRAME_BITS)) gap <= gap + GAP_W'(1);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!cmd_valid && cmd_code == 2'd0));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  assert_frame_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (gap == GAP_W'(FRAME_BITS)));

  assert_code_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> $stable(cmd_code));

  logic unused_in;
  assign unused_in = cmd_in;
endmodule

bind emmc_boot_cmd_decoder emmc_boot_cmd_decoder_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .cmd_in    (cmd_in),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code)
);

// File: tb/emmc_boot_cmd_decoder_bench.sv
`timescale 1ns/1ps
module emmc_boot_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_in = 1'b1;
  logic       cmd_valid;
  logic [1:0] cmd_code;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [1:0] last_code = 2'd0;
  bit finished = 1'b0;

  localparam logic [47:0] F_IDLE = 48'h400000000095;
  localparam logic [47:0] F_PRE  = 48'h40F0F0F0F0FD;
  localparam logic [47:0] F_BOOT = 48'h40FFFFFFFAE5;

  always #2.5 clk = ~clk;

  emmc_boot_cmd_decoder u_emmc_boot_cmd_decoder (
    .clk(clk), .rst(rst), .cmd_in(cmd_in),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      pulses    <= pulses + 1;
      last_code <= cmd_code;
    end
  end

  function automatic logic [1:0] expect_code(logic [47:0] f);
    if (f == F_IDLE) return 2'd0;
    if (f == F_PRE)  return 2'd1;
    if (f == F_BOOT) return 2'd2;
    return 2'd3;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    cmd_in = b;
  endtask

  task automatic send_idle(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_frame(logic [47:0] f);
    for (int i = 47; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic run_frame(logic [47:0] f, int gap, string req);
    int p0;
    send_idle(gap);
    p0 = pulses;
    send_frame(f);
    send_idle(3);
    @(negedge clk);
    check(pulses == p0 + 1, req, pulses - p0, 1);
    check(last_code == expect_code(f), req, last_code, expect_code(f));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cmd_valid == 1'b0, "R1", cmd_valid, 0);
    check(cmd_code == 2'd0, "R1", cmd_code, 0);

    // R2 long idle run yields no pulse
    send_idle(500);
    check(pulses == 0, "R2", pulses, 0);

    // R8 exact pulse timing on a boot frame
    send_frame(F_BOOT);
    send_bit(1'b1);
    check(cmd_valid == 1'b0, "R8", cmd_valid, 0);
    send_bit(1'b1);
    check(cmd_valid == 1'b1, "R8", cmd_valid, 1);
    check(cmd_code == 2'd2, "R6", cmd_code, 2);
    send_bit(1'b1);
    check(cmd_valid == 1'b0, "R8", cmd_valid, 0);

    // R10 code held between pulses
    send_idle(20);
    check(cmd_code == 2'd2, "R10", cmd_code, 2);

    // R3..R6 known frames at varying alignments
    for (int g = 1; g <= 8; g++) begin
      run_frame(F_IDLE, g, "R4");
      run_frame(F_PRE, g + 3, "R5");
      run_frame(F_BOOT, g + 7, "R6");
    end

    // R7 every single-bit corruption below the start bit
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 47; k++) begin
        logic [47:0] base;
        base = (p == 0) ? F_IDLE : (p == 1) ? F_PRE : F_BOOT;
        run_frame(base ^ (48'd1 << k), ((p * 47 + k) % 11) + 1, "R7");
      end
    end
    run_frame(48'h000000000000, 2, "R7");
    run_frame(48'h7FFFFFFFFFFF, 5, "R7");

    // R9 zeros after a frame are ignored; one idle bit re-arms
    p0 = pulses;
    send_frame(F_BOOT);
    for (int i = 0; i < 60; i++) send_bit(1'b0);
    check(pulses == p0 + 1, "R9", pulses - p0, 1);
    check(last_code == 2'd2, "R9", last_code, 2);
    send_bit(1'b1);
    send_frame(F_PRE);
    send_bit(1'b1);
    send_frame(F_IDLE);
    send_idle(3);
    @(negedge clk);
    check(pulses == p0 + 3, "R9", pulses - p0, 3);
    check(last_code == 2'd0, "R9", last_code, 0);

    // R11 reset mid-frame discards the partial frame
    send_idle(4);
    p0 = pulses;
    for (int i = 47; i >= 28; i--) send_bit(F_BOOT[i]);
    @(negedge clk);
    rst = 1'b1;
    cmd_in = 1'b1;
    repeat (2) @(negedge clk);
    check(cmd_valid == 1'b0 && cmd_code == 2'd0, "R11", cmd_code, 0);
    rst = 1'b0;
    send_idle(60);
    check(pulses == p0, "R11", pulses - p0, 0);
    run_frame(F_PRE, 3, "R11");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule